// File: doc/BRIEF.md
# System Management Mode Sequencer

This block runs a processor core's way into and out of system management mode. When a management interrupt request arrives while the core is in normal operation, the block copies the architectural state, one 32-bit word per cycle, into a save area in management RAM. It then loads the fixed entry values for the segment, control and debug registers and points the instruction pointer at the handler. When the handler executes its resume instruction, the block reads the save area back into the registers. It then rebuilds the privilege level and the segment valid and default-size bits from the restored words.

The core register file is outside the block. The block sees it as an indexed array of 32-bit words with one read port and a load strobe. The save area sits behind a simple memory port with a combinational read. The block also drives the "in management mode" indication and owns the non-maskable interrupt gate. That gate blocks such interrupts while the block is in the mode, remembers one that arrives meanwhile, and hands it over once the mode is left. A resume instruction issued outside the mode turns into an invalid-opcode trap.

Top module: `smm_seq`

## Requirements
- R1: After reset, `busy`, `smiact`, `done` and `trap_valid` are low, all six `seg_valid` bits are high, and the save-area base register holds 0x30000.
- R2: A `smi_req` sampled while idle and outside the mode sets `smiact` at that edge. `busy` is then high for exactly 81 cycles (52 save cycles, then 29 entry loads), and `done` is high for one cycle as `busy` falls.
- R3: Register indices are: 0-7 general registers, 8 instruction pointer, 9 flags, 10 CR0, 11 CR3, 12 CR4, 13 DR6, 14 DR7. Segment s (ES=0, CS=1, SS=2, DS=3, FS=4, GS=5) uses 15+4s selector, 16+4s base, 17+4s limit and 18+4s access. 39-42 hold the local table, 43-46 the task register, 47-48 the global table base and limit, and 49-50 the interrupt table base and limit. Save slot k (k<51) holds register k at address B+0xFE00+0x1FC-4k, where B is the save-area base register. Slot 51 holds B itself at B+0xFE00+0x130. The save writes slot 0 first, and every value is taken before any entry load.
- R4: After entry, the CS selector is 0x3000, the CS base is the save-area base register, the CS limit is 0xFFFFFFFF, the CS access word is 0x809B, and the instruction pointer is 0x8000.
- R5: After entry, ES, SS, DS, FS and GS have selector 0, base 0, limit 0xFFFFFFFF and access 0x8093, and all `seg_valid` bits are high. CR4 is 0, DR7 is 0x400, the flags are 0x00000002, and CR0 is its old value with bits 31, 3, 2 and 0 cleared.
- R6: A `smi_req` while already in the mode starts no walk, writes no memory, and is not remembered.
- R7: A `nmi_req` while in the mode produces no trap and is held pending.
- R8: A `rsm_req` while idle outside the mode gives `trap_valid` with `trap_vec` = 6 one cycle later, starts no walk and loads no register.
- R9: A `rsm_req` while idle in the mode reads all 52 slots, addressed from the base in force when the walk starts, and loads each into its register; slot 51 reloads the save-area base register, which the next entry then uses. `busy` lasts 52 cycles.
- R10: After a resume, `cpl` equals bits 14:13 of the restored SS access word.
- R11: After a resume with CR0 bit 0 set and flags bit 17 clear, `seg_valid[s]` is high only if the restored selector of segment s is nonzero, and `seg_dflt[s]` is access bit 14. Otherwise all `seg_valid` bits are high.
- R12: At the edge that ends a resume, `smiact` falls, the interrupt gate opens, and a held non-maskable interrupt is delivered once, with `trap_vec` = 2, in the cycle after `done`.
- R13: Outside the mode, a `nmi_req` sampled at one edge raises `trap_valid` with `trap_vec` = 2 at the next edge, for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smi_req | input | 1 | Management interrupt request, one-cycle pulse |
| rsm_req | input | 1 | Resume instruction decoded, one-cycle pulse |
| nmi_req | input | 1 | Non-maskable interrupt request, one-cycle pulse |
| mem_we | output | 1 | Save-area write strobe |
| mem_re | output | 1 | Save-area read strobe |
| mem_addr | output | 32 | Save-area word address (byte address) |
| mem_wdata | output | 32 | Save-area write data |
| mem_rdata | input | 32 | Save-area read data, valid in the same cycle |
| rf_idx | output | IDX_W | Register file index for read and load |
| rf_we | output | 1 | Register file load strobe |
| rf_wdata | output | 32 | Register file load data |
| rf_rdata | input | 32 | Register file read data at `rf_idx` |
| smiact | output | 1 | Core is in management mode |
| busy | output | 1 | Save, entry or restore walk in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| trap_valid | output | 1 | Trap request pulse to the core |
| trap_vec | output | 8 | Trap vector (2 or 6) |
| cpl | output | 2 | Privilege level rebuilt on resume |
| seg_valid | output | 6 | Per-segment valid bits (ES..GS) |
| seg_dflt | output | 6 | Per-segment default-size bits (ES..GS) |

## Verification
The assertions assume that `smi_req`, `rsm_req` and `nmi_req` are single-cycle pulses. They also assume that the register file and save area answer reads in the same cycle, and that `rsm_req` and `smi_req` are not raised together outside the mode. The stimulus drives every request for exactly one cycle on the falling edge and issues a new request only after the previous walk has finished. Its register file and save-area models reply combinationally from `rf_idx` and from address bits 8:2.

// File: rtl/smm_pkg.sv
package smm_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned R_EIP      = 8;
  localparam int unsigned R_FLAGS    = 9;
  localparam int unsigned R_CR0      = 10;
  localparam int unsigned R_CR3      = 11;
  localparam int unsigned R_CR4      = 12;
  localparam int unsigned R_DR6      = 13;
  localparam int unsigned R_DR7      = 14;
  localparam int unsigned R_SEG0     = 15;
  localparam int unsigned N_SEG      = 6;
  localparam int unsigned SEG_FIELDS = 4;
  localparam int unsigned SEG_CS     = 1;
  localparam int unsigned SEG_SS     = 2;
  localparam int unsigned FLD_SEL    = 0;
  localparam int unsigned FLD_ACC    = 3;
  localparam int unsigned N_REG      = 51;
  localparam int unsigned N_SLOT     = N_REG + 1;
  localparam int unsigned N_SEGW     = N_SEG * SEG_FIELDS;
  localparam int unsigned N_ENTRY    = N_SEGW + 5;
  localparam int unsigned SLOT_TOP   = 9'h1FC;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SAVE  = 2'd1,
    ST_ENTER = 2'd2,
    ST_LOAD  = 2'd3
  } smm_state_e;
endpackage

// File: rtl/smm_slot_map.sv
module smm_slot_map
  import smm_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int IDX_W = 6,
  parameter int OFS_W = 9
) (
  input  logic [CNT_W-1:0] slot,
  output logic [IDX_W-1:0] reg_idx,
  output logic [OFS_W-1:0] ofs,
  output logic             is_base,
  output logic             seg_hit,
  output logic [2:0]       seg_num,
  output logic [1:0]       seg_fld
);
  localparam int SEG_END = R_SEG0 + N_SEGW;

  logic [CNT_W-1:0] rel;

  always_comb begin
    reg_idx = IDX_W'(slot);
    ofs     = OFS_W'(SLOT_TOP) - OFS_W'({slot, 2'b00});
    is_base = (slot == CNT_W'(N_REG));
    seg_hit = (slot >= CNT_W'(R_SEG0)) && (slot < CNT_W'(SEG_END));
    rel     = slot - CNT_W'(R_SEG0);
    seg_num = 3'(rel >> 2);
    seg_fld = rel[1:0];
  end
endmodule

// File: rtl/smm_entry_map.sv
module smm_entry_map
  import smm_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int IDX_W = 6
) (
  input  logic [CNT_W-1:0]  item,
  input  logic [WORD_W-1:0] smbase,
  input  logic [WORD_W-1:0] cr0_cur,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [WORD_W-1:0] value
);
  localparam logic [WORD_W-1:0] CS_SEL_ENTRY   = 32'h0000_3000;
  localparam logic [WORD_W-1:0] CS_ACC_ENTRY   = 32'h0000_809B;
  localparam logic [WORD_W-1:0] DATA_ACC_ENTRY = 32'h0000_8093;
  localparam logic [WORD_W-1:0] FLAT_LIMIT     = 32'hFFFF_FFFF;
  localparam logic [WORD_W-1:0] CR0_CLR_MASK   = 32'h8000_000D;
  localparam logic [WORD_W-1:0] FLAGS_ENTRY    = 32'h0000_0002;
  localparam logic [WORD_W-1:0] IP_ENTRY       = 32'h0000_8000;
  localparam logic [WORD_W-1:0] DR7_ENTRY      = 32'h0000_0400;

  logic             is_cs;
  logic [CNT_W-1:0] k;

  always_comb begin
    reg_idx = '0;
    value   = '0;
    is_cs   = ((item >> 2) == CNT_W'(SEG_CS));
    k       = item - CNT_W'(N_SEGW);
    if (item < CNT_W'(N_SEGW)) begin
      reg_idx = IDX_W'(item) + IDX_W'(R_SEG0);
      case (item[1:0])
        2'd0:    value = is_cs ? CS_SEL_ENTRY : '0;
        2'd1:    value = is_cs ? smbase : '0;
        2'd2:    value = FLAT_LIMIT;
        default: value = is_cs ? CS_ACC_ENTRY : DATA_ACC_ENTRY;
      endcase
    end else begin
      case (k)
        CNT_W'(0): begin reg_idx = IDX_W'(R_CR0);   value = cr0_cur & ~CR0_CLR_MASK; end
        CNT_W'(1): begin reg_idx = IDX_W'(R_FLAGS); value = FLAGS_ENTRY; end
        CNT_W'(2): begin reg_idx = IDX_W'(R_EIP);   value = IP_ENTRY; end
        CNT_W'(3): begin reg_idx = IDX_W'(R_CR4);   value = '0; end
        default:   begin reg_idx = IDX_W'(R_DR7);   value = DR7_ENTRY; end
      endcase
    end
  end
endmodule

// File: rtl/smm_nmi_gate.sv
module smm_nmi_gate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nmi_req,
  input  logic       mask_set,
  input  logic       mask_clr,
  input  logic       bad_rsm,
  output logic       mask_q,
  output logic       trap_valid,
  output logic [7:0] trap_vec
);
  localparam logic [7:0] VEC_NMI = 8'd2;
  localparam logic [7:0] VEC_UD  = 8'd6;

  logic       pend_q, pend_n, mask_n, tv_n, deliver;
  logic [7:0] vec_n;

  always_comb begin
    deliver = pend_q && !mask_q && !bad_rsm;
    pend_n  = (pend_q || nmi_req) && !deliver;
    mask_n  = mask_set ? 1'b1 : (mask_clr ? 1'b0 : mask_q);
    tv_n    = bad_rsm || deliver;
    vec_n   = bad_rsm ? VEC_UD : VEC_NMI;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      mask_q     <= 1'b0;
      trap_valid <= 1'b0;
      trap_vec   <= VEC_NMI;
    end else begin
      pend_q     <= pend_n;
      mask_q     <= mask_n;
      trap_valid <= tv_n;
      trap_vec   <= vec_n;
    end
  end

  AST_NMI_NOT_WHILE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_vec == VEC_NMI) |-> !$past(mask_q)) else $error("nmi through gate"); // R7
  AST_TRAP_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (trap_vec == VEC_NMI || trap_vec == VEC_UD)) else $error("bad vector"); // R13
  AST_TRAP_ONE_CYCLE_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_vec == VEC_NMI) |=> !(trap_valid && trap_vec == VEC_NMI)) else $error("nmi twice"); // R12
endmodule

// File: rtl/smm_seq.sv
module smm_seq
  import smm_pkg::*;
#(
  parameter logic [31:0] SMBASE_RST = 32'h0003_0000,
  parameter logic [31:0] AREA_OFS   = 32'h0000_FE00,
  parameter int          IDX_W      = $clog2(N_SLOT),
  parameter int          CNT_W      = $clog2(N_SLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smi_req,
  input  logic             rsm_req,
  input  logic             nmi_req,
  output logic             mem_we,
  output logic             mem_re,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic [IDX_W-1:0] rf_idx,
  output logic             rf_we,
  output logic [31:0]      rf_wdata,
  input  logic [31:0]      rf_rdata,
  output logic             smiact,
  output logic             busy,
  output logic             done,
  output logic             trap_valid,
  output logic [7:0]       trap_vec,
  output logic [1:0]       cpl,
  output logic [5:0]       seg_valid,
  output logic [5:0]       seg_dflt
);
  localparam int OFS_W = 9;

  smm_state_e       st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [31:0]      smbase_q, smbase_n, area_q, area_n;
  logic             smiact_n, done_n;
  logic [1:0]       cpl_n;
  logic [5:0]       valid_n, dflt_n;

  logic [IDX_W-1:0] slot_idx, ent_idx;
  logic [OFS_W-1:0] slot_ofs;
  logic             slot_base, seg_hit;
  logic [2:0]       seg_num;
  logic [1:0]       seg_fld;
  logic [31:0]      ent_val;

  logic             accept_smi, start_rsm, bad_rsm, last_slot, last_entry, load_go, mask_q;
  logic [5:0]       sel_nz_q, acc14_q;
  logic [1:0]       ss_dpl_q;
  logic             pe_q, vm_q, prot;

  smm_slot_map #(.CNT_W(CNT_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_slot (
    .slot(cnt_q), .reg_idx(slot_idx), .ofs(slot_ofs), .is_base(slot_base),
    .seg_hit(seg_hit), .seg_num(seg_num), .seg_fld(seg_fld)
  );

  smm_entry_map #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_entry (
    .item(cnt_q), .smbase(smbase_q), .cr0_cur(rf_rdata),
    .reg_idx(ent_idx), .value(ent_val)
  );

  smm_nmi_gate u_nmi (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req),
    .mask_set(accept_smi), .mask_clr(load_go && last_slot), .bad_rsm(bad_rsm),
    .mask_q(mask_q), .trap_valid(trap_valid), .trap_vec(trap_vec)
  );

  // request decode and walk limits
  always_comb begin
    accept_smi = (st_q == ST_IDLE) && smi_req && !smiact;
    start_rsm  = (st_q == ST_IDLE) && rsm_req && smiact;
    bad_rsm    = (st_q == ST_IDLE) && rsm_req && !smiact && !smi_req;
    last_slot  = (cnt_q == CNT_W'(N_SLOT - 1));
    last_entry = (cnt_q == CNT_W'(N_ENTRY - 1));
    load_go    = (st_q == ST_LOAD);
    prot       = pe_q && !vm_q;
  end

  // memory and register file ports
  always_comb begin
    busy      = (st_q != ST_IDLE);
    mem_we    = (st_q == ST_SAVE);
    mem_re    = load_go;
    mem_addr  = area_q + {{(32-OFS_W){1'b0}}, slot_ofs};
    mem_wdata = slot_base ? smbase_q : rf_rdata;
    rf_idx    = (st_q == ST_ENTER) ? ent_idx : slot_idx;
    rf_we     = (st_q == ST_ENTER) || (load_go && !slot_base);
    rf_wdata  = (st_q == ST_ENTER) ? ent_val : mem_rdata;
  end

  // sequencer next state
  always_comb begin
    st_n     = st_q;
    cnt_n    = cnt_q;
    smbase_n = smbase_q;
    area_n   = area_q;
    smiact_n = smiact;
    done_n   = 1'b0;
    cpl_n    = cpl;
    valid_n  = seg_valid;
    dflt_n   = seg_dflt;
    unique case (st_q)
      ST_IDLE: begin
        if (accept_smi) begin
          st_n     = ST_SAVE;
          cnt_n    = '0;
          smiact_n = 1'b1;
          area_n   = smbase_q + AREA_OFS;
        end else if (start_rsm) begin
          st_n   = ST_LOAD;
          cnt_n  = '0;
          area_n = smbase_q + AREA_OFS;
        end
      end
      ST_SAVE: begin
        cnt_n = cnt_q + 1'b1;
        if (last_slot) begin
          st_n  = ST_ENTER;
          cnt_n = '0;
        end
      end
      ST_ENTER: begin
        cnt_n = cnt_q + 1'b1;
        if (last_entry) begin
          st_n    = ST_IDLE;
          cnt_n   = '0;
          done_n  = 1'b1;
          valid_n = '1;
        end
      end
      ST_LOAD: begin
        cnt_n = cnt_q + 1'b1;
        if (slot_base) smbase_n = mem_rdata;
        if (last_slot) begin
          st_n     = ST_IDLE;
          cnt_n    = '0;
          done_n   = 1'b1;
          smiact_n = 1'b0;
          cpl_n    = ss_dpl_q;
          valid_n  = prot ? sel_nz_q : '1;
          dflt_n   = prot ? acc14_q : seg_dflt;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      smbase_q  <= SMBASE_RST;
      area_q    <= '0;
      smiact    <= 1'b0;
      done      <= 1'b0;
      cpl       <= 2'd0;
      seg_valid <= '1;
      seg_dflt  <= '0;
    end else begin
      st_q      <= st_n;
      cnt_q     <= cnt_n;
      smbase_q  <= smbase_n;
      area_q    <= area_n;
      smiact    <= smiact_n;
      done      <= done_n;
      cpl       <= cpl_n;
      seg_valid <= valid_n;
      seg_dflt  <= dflt_n;
    end
  end

  // per-segment capture of restored selector and access bits
  for (genvar s = 0; s < N_SEG; s++) begin : g_seg
    logic sel_en, acc_en;
    assign sel_en = load_go && seg_hit && (seg_num == 3'(s)) && (seg_fld == 2'(FLD_SEL));
    assign acc_en = load_go && seg_hit && (seg_num == 3'(s)) && (seg_fld == 2'(FLD_ACC));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_nz_q[s] <= 1'b0;
        acc14_q[s]  <= 1'b0;
      end else begin
        if (sel_en) sel_nz_q[s] <= (mem_rdata != '0);
        if (acc_en) acc14_q[s]  <= mem_rdata[14];
      end
    end
  end

  logic ss_en, cr0_en, flg_en;
  assign ss_en  = load_go && seg_hit && (seg_num == 3'(SEG_SS)) && (seg_fld == 2'(FLD_ACC));
  assign cr0_en = load_go && (slot_idx == IDX_W'(R_CR0));
  assign flg_en = load_go && (slot_idx == IDX_W'(R_FLAGS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_dpl_q <= 2'd0;
      pe_q     <= 1'b0;
      vm_q     <= 1'b0;
    end else begin
      if (ss_en)  ss_dpl_q <= mem_rdata[14:13];
      if (cr0_en) pe_q     <= mem_rdata[0];
      if (flg_en) vm_q     <= mem_rdata[17];
    end
  end

  AST_LOAD_ONLY_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> busy) else $error("load outside walk"); // R2
  AST_DONE_CLOSES_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy)) else $error("stray done"); // R2
  AST_ONE_MEM_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)) else $error("read and write together"); // R3
  AST_SMI_IN_MODE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && smiact && smi_req && !rsm_req) |=> !busy) else $error("smi in mode"); // R6
  AST_BAD_RSM_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !smiact && rsm_req && !smi_req) |=> (!busy && trap_valid)) else $error("bad rsm"); // R8
  AST_MODE_EXIT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(smiact) |-> done) else $error("exit without done"); // R12
  AST_GATE_TRACKS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    smiact == mask_q) else $error("gate out of step"); // R7
endmodule

// File: tb/tb_smm_seq.sv
module tb_smm_seq;
  logic        clk, rst_n, smi_req, rsm_req, nmi_req;
  logic        mem_we, mem_re, rf_we, smiact, busy, done, trap_valid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_wdata, rf_rdata;
  logic [5:0]  rf_idx;
  logic [7:0]  trap_vec;
  logic [1:0]  cpl;
  logic [5:0]  seg_valid, seg_dflt;

  logic [31:0] rf [0:63];
  logic [31:0] sm [0:127];

  int n_chk, n_fail;
  int trap_cnt, busy_cyc, done_cnt, wr_cnt, rd_cnt;
  logic [7:0]  last_vec;
  logic [31:0] first_wr, first_rd;

  smm_seq dut (
    .clk(clk), .rst_n(rst_n), .smi_req(smi_req), .rsm_req(rsm_req), .nmi_req(nmi_req),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rf_idx(rf_idx), .rf_we(rf_we), .rf_wdata(rf_wdata),
    .rf_rdata(rf_rdata), .smiact(smiact), .busy(busy), .done(done),
    .trap_valid(trap_valid), .trap_vec(trap_vec), .cpl(cpl),
    .seg_valid(seg_valid), .seg_dflt(seg_dflt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always_comb rf_rdata  = rf[rf_idx];
  always_comb mem_rdata = sm[mem_addr[8:2]];

  always @(posedge clk) begin
    if (rf_we) rf[rf_idx] <= rf_wdata;
    if (mem_we) begin
      sm[mem_addr[8:2]] <= mem_wdata;
      if (wr_cnt == 0) first_wr <= mem_addr;
      wr_cnt <= wr_cnt + 1;
    end
    if (mem_re) begin
      if (rd_cnt == 0) first_rd <= mem_addr;
      rd_cnt <= rd_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (trap_valid) begin trap_cnt <= trap_cnt + 1; last_vec <= trap_vec; end
    if (busy) busy_cyc <= busy_cyc + 1;
    if (done) done_cnt <= done_cnt + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr_mon();
    @(negedge clk);
    trap_cnt = 0; busy_cyc = 0; done_cnt = 0; wr_cnt = 0; rd_cnt = 0;
  endtask

  task automatic pulse_smi();
    @(negedge clk) smi_req = 1'b1;
    @(negedge clk) smi_req = 1'b0;
  endtask

  task automatic pulse_rsm();
    @(negedge clk) rsm_req = 1'b1;
    @(negedge clk) rsm_req = 1'b0;
  endtask

  task automatic pulse_nmi();
    @(negedge clk) nmi_req = 1'b1;
    @(negedge clk) nmi_req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 busy", 32'(busy), 0);
    chk("R1 smiact", 32'(smiact), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 trap", 32'(trap_valid), 0);
    chk("R1 seg_valid", 32'(seg_valid), 32'h3F);
  endtask

  task automatic t_smi_entry();
    logic [31:0] cr0_old;
    for (int k = 0; k < 51; k++) rf[k] = 32'h1000_0000 + k * 32'h111;
    cr0_old = rf[10];
    clr_mon();
    pulse_smi();
    chk("R2 smiact on accept", 32'(smiact), 1);
    repeat (90) @(negedge clk);
    chk("R2 busy cycles", 32'(busy_cyc), 81);
    chk("R2 done pulses", 32'(done_cnt), 1);
    chk("R3 first write addr", first_wr, 32'h0003_FFFC);
    chk("R3 write count", 32'(wr_cnt), 52);
    for (int k = 0; k < 51; k++)
      chk($sformatf("R3 slot %0d", k), sm[127 - k], 32'h1000_0000 + k * 32'h111);
    chk("R3 base slot", sm[76], 32'h0003_0000);
    chk("R4 cs sel", rf[19], 32'h3000);
    chk("R4 cs base", rf[20], 32'h0003_0000);
    chk("R4 cs limit", rf[21], 32'hFFFF_FFFF);
    chk("R4 cs access", rf[22], 32'h809B);
    chk("R4 ip", rf[8], 32'h8000);
    for (int s = 0; s < 6; s++) begin
      if (s != 1) begin
        chk($sformatf("R5 seg%0d sel", s), rf[15 + 4*s], 0);
        chk($sformatf("R5 seg%0d base", s), rf[16 + 4*s], 0);
        chk($sformatf("R5 seg%0d limit", s), rf[17 + 4*s], 32'hFFFF_FFFF);
        chk($sformatf("R5 seg%0d access", s), rf[18 + 4*s], 32'h8093);
      end
    end
    chk("R5 cr4", rf[12], 0);
    chk("R5 dr7", rf[14], 32'h400);
    chk("R5 flags", rf[9], 2);
    chk("R5 cr0", rf[10], cr0_old & ~32'h8000_000D);
    chk("R5 seg_valid", 32'(seg_valid), 32'h3F);
  endtask

  task automatic t_smi_ignored();
    clr_mon();
    pulse_smi();
    repeat (100) @(negedge clk);
    chk("R6 no walk", 32'(busy_cyc), 0);
    chk("R6 no write", 32'(wr_cnt), 0);
    chk("R6 still in mode", 32'(smiact), 1);
  endtask

  task automatic t_nmi_masked();
    clr_mon();
    pulse_nmi();
    repeat (6) @(negedge clk);
    chk("R7 no trap in mode", 32'(trap_cnt), 0);
  endtask

  task automatic t_rsm_restore();
    logic [31:0] exp_w [0:50];
    for (int k = 0; k < 51; k++) exp_w[k] = 32'hA000_0000 + k;
    exp_w[27] = 0;  exp_w[35] = 0;
    exp_w[18] = 32'h4093; exp_w[22] = 32'h409B; exp_w[26] = 32'h6093;
    exp_w[30] = 32'h0093; exp_w[34] = 32'h0093; exp_w[38] = 32'h0093;
    exp_w[10] = 32'h11;   exp_w[9]  = 32'h202;
    for (int k = 0; k < 51; k++) sm[127 - k] = exp_w[k];
    sm[76] = 32'h0005_0000;
    clr_mon();
    pulse_rsm();
    repeat (60) @(negedge clk);
    chk("R9 busy cycles", 32'(busy_cyc), 52);
    chk("R9 first read addr", first_rd, 32'h0003_FFFC);
    for (int k = 0; k < 51; k++)
      chk($sformatf("R9 reg %0d", k), rf[k], exp_w[k]);
    chk("R10 cpl", 32'(cpl), 3);
    chk("R11 valid prot", 32'(seg_valid), 32'b010111);
    chk("R11 dflt prot", 32'(seg_dflt), 32'b000111);
    chk("R12 smiact low", 32'(smiact), 0);
    chk("R12 held nmi count", 32'(trap_cnt), 1);
    chk("R12 held nmi vec", 32'(last_vec), 2);
  endtask

  task automatic t_rsm_bad();
    logic [31:0] ip;
    ip = rf[8];
    clr_mon();
    @(negedge clk) rsm_req = 1'b1;
    @(negedge clk) rsm_req = 1'b0;
    chk("R8 trap", 32'(trap_valid), 1);
    chk("R8 vec", 32'(trap_vec), 6);
    repeat (5) @(negedge clk);
    chk("R8 no walk", 32'(busy_cyc), 0);
    chk("R8 ip kept", rf[8], ip);
  endtask

  task automatic t_nmi_open();
    clr_mon();
    pulse_nmi();
    chk("R13 not yet", 32'(trap_valid), 0);
    @(negedge clk);
    chk("R13 trap", 32'(trap_valid), 1);
    chk("R13 vec", 32'(trap_vec), 2);
    repeat (4) @(negedge clk);
    chk("R13 single", 32'(trap_cnt), 1);
  endtask

  task automatic t_rebased();
    clr_mon();
    pulse_smi();
    repeat (90) @(negedge clk);
    chk("R9 new base used", first_wr, 32'h0005_FFFC);
    chk("R4 cs base new", rf[20], 32'h0005_0000);
  endtask

  task automatic t_rsm_real();
    sm[127 - 10] = 32'h0;
    sm[127 - 27] = 32'h0;
    sm[127 - 26] = 32'h2093;
    clr_mon();
    pulse_rsm();
    repeat (60) @(negedge clk);
    chk("R11 valid real", 32'(seg_valid), 32'h3F);
    chk("R10 cpl real", 32'(cpl), 1);
    chk("R9 first read new base", first_rd, 32'h0005_FFFC);
    chk("R12 no extra nmi", 32'(trap_cnt), 0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    trap_cnt = 0; busy_cyc = 0; done_cnt = 0; wr_cnt = 0; rd_cnt = 0;
    last_vec = '0; first_wr = '0; first_rd = '0;
    smi_req = 0; rsm_req = 0; nmi_req = 0;
    for (int i = 0; i < 64; i++) rf[i] = '0;
    for (int i = 0; i < 128; i++) sm[i] = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_smi_entry();
    t_smi_ignored();
    t_nmi_masked();
    t_rsm_restore();
    t_rsm_bad();
    t_nmi_open();
    t_rebased();
    t_rsm_real();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule